// File: doc/BRIEF.md
# PHY Control-Bus Access Sequencer

This block is a hardware master for a set of 16-bit PHY registers that sit behind a single control word and a single status word instead of being memory-mapped. A client posts one request with an operation (read or write), a 16-bit register address and 16-bit write data. The sequencer then steps the control word through a fixed series of strobes. Each strobe is a full four-phase handshake: the strobe is raised, the PHY acknowledge is awaited high, the strobe is dropped, and the acknowledge is awaited low.

Every acknowledge wait polls the status word at a fixed cycle spacing for a bounded number of polls. If the expected acknowledge level is not seen within that bound, the sequence aborts, the control word returns to zero and the response reports an error. A completed read returns the 16 bits that the PHY presented while it acknowledged the read strobe. The block accepts a new request only while it is idle and signals completion with a one-cycle done pulse.

Top module: `phy_cbus_master`

## Requirements
- R1: After reset the control word is 0, the block is ready, done and error are low, and the read data is 0.
- R2: Control word field positions: bits 15:0 carry address or data, bit 16 is address-capture, bit 17 is data-capture, bit 18 is the write strobe and bit 19 is the read strobe; no more than one of bits 19:16 is ever set.
- R3: Status word field positions: bits 15:0 carry PHY read data and bit 16 is the acknowledge.
- R4: Every transaction begins with the address step: the word goes to address with bit 16 set, and after ack=1 it goes to the bare address; the block then waits for ack=0.
- R5: A write then runs data-capture (data with bit 17 set, then bare data after ack=1, then waits for ack=0), then the write strobe (word 0x40000, after ack=1 back to bare data, then waits for ack=0), and finally sets the word to 0.
- R6: A read, after the address step, sets the word to 0x80000, waits for ack=1, samples status bits 15:0 into the read data output in that cycle, sets the word to 0 and waits for ack=0.
- R7: The first poll of each wait falls POLL_GAP cycles after the control word changes and later polls follow every POLL_GAP cycles; an expected ack seen at any of the first POLL_LIMIT polls advances the sequence at the next clock edge.
- R8: If POLL_LIMIT polls of one wait all miss, the control word is set to 0 after holding its value for exactly POLL_LIMIT*POLL_GAP cycles, and done is reported together with error; no later step of that transaction takes place.
- R9: A request is taken only while ready is high; a request presented while a transaction is running has no effect on the control word or the PHY registers.
- R10: Done is high for exactly one cycle per transaction, error is high only together with done, and read data is cleared to 0 when a request is taken and then holds its value until the next request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 16 | PHY register address |
| reqWdata | input | 16 | Write data |
| reqReady | output | 1 | Block idle, a request is taken this cycle |
| rspDone | output | 1 | One-cycle completion pulse |
| rspErr | output | 1 | Acknowledge timeout, valid with rspDone |
| rspRdata | output | 16 | Read result |
| ctlWord | output | 20 | Control word to the PHY (bits 19:0) |
| statWord | input | 17 | Status word from the PHY (bits 16:0) |

## Verification
A PHY responder model with programmable acknowledge latency and two stuck modes records every distinct control word, so writes and reads are compared against the exact expected word sequence. Write/read-back pairs over several addresses and data values (including all-ones) separate correct data capture from address/data mix-ups. Latencies of 1, 3, 4, 19 and 20 cycles give word hold times that distinguish the poll spacing and locate the last allowed poll. An acknowledge that never rises and one that never falls show the abort path at two different steps, and a request poked during a busy write, followed by a read-back of the poked address, shows it was ignored.

// File: rtl/phy_cbus_pkg.sv
package phy_cbus_pkg;
  localparam int PAY_W    = 16;
  localparam int CAPA_BIT = 16;
  localparam int CAPD_BIT = 17;
  localparam int WR_BIT   = 18;
  localparam int RD_BIT   = 19;
  localparam int CTL_W    = RD_BIT + 1;
  localparam int ACK_BIT  = 16;
  localparam int STAT_W   = ACK_BIT + 1;

  typedef enum logic [2:0] {
    W_ZERO, W_ADDR_CAP, W_ADDR, W_DATA_CAP, W_DATA, W_WR, W_RD
  } wordSel_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_ADDR_HI, ST_ADDR_LO, ST_DATA_HI, ST_DATA_LO,
    ST_WR_HI, ST_WR_LO, ST_RD_HI, ST_RD_LO
  } seqState_e;

  typedef struct packed {
    logic     latchReq;
    logic     loadWord;
    wordSel_e sel;
    logic     captureRd;
    logic     clearRd;
    logic     pollRun;
  } dpStrobes_t;
endpackage

// File: rtl/phy_cbus_dpath.sv
module phy_cbus_dpath
  import phy_cbus_pkg::*;
#(
  parameter int POLL_GAP   = 2,
  parameter int POLL_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [PAY_W-1:0]  reqAddr,
  input  logic [PAY_W-1:0]  reqWdata,
  input  logic [STAT_W-1:0] statWord,
  output logic [CTL_W-1:0]  ctlWord,
  output logic [PAY_W-1:0]  rdData,
  output logic              pollTick,
  output logic              lastPoll,
  output logic              ackIn
);
  localparam int CNT_W = $clog2(POLL_LIMIT + 1);

  logic [PAY_W-1:0] addrQ, dataQ;
  logic [PAY_W-1:0] addrSrc, dataSrc;
  logic [CTL_W-1:0] ctlQ, ctlNxt;
  logic [CNT_W-1:0] pollCnt;

  assign addrSrc = strb.latchReq ? reqAddr  : addrQ;
  assign dataSrc = strb.latchReq ? reqWdata : dataQ;
  assign ackIn   = statWord[ACK_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else if (strb.latchReq) begin
      addrQ <= reqAddr;
      dataQ <= reqWdata;
    end
  end

  always_comb begin
    ctlNxt = '0;
    case (strb.sel)
      W_ADDR_CAP: begin ctlNxt[PAY_W-1:0] = addrSrc; ctlNxt[CAPA_BIT] = 1'b1; end
      W_ADDR:     ctlNxt[PAY_W-1:0] = addrSrc;
      W_DATA_CAP: begin ctlNxt[PAY_W-1:0] = dataSrc; ctlNxt[CAPD_BIT] = 1'b1; end
      W_DATA:     ctlNxt[PAY_W-1:0] = dataSrc;
      W_WR:       ctlNxt[WR_BIT] = 1'b1;
      W_RD:       ctlNxt[RD_BIT] = 1'b1;
      default:    ctlNxt = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              ctlQ <= '0;
    else if (strb.loadWord) ctlQ <= ctlNxt;
  end
  assign ctlWord = ctlQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               rdData <= '0;
    else if (strb.clearRd)   rdData <= '0;
    else if (strb.captureRd) rdData <= statWord[PAY_W-1:0];
  end

  // Poll spacing: a parameter picks a plain every-cycle poll or a gap counter.
  generate
    if (POLL_GAP == 1) begin : g_gap_none
      assign pollTick = strb.pollRun;
    end else begin : g_gap_cnt
      localparam int GAP_W = $clog2(POLL_GAP);
      logic [GAP_W-1:0] gapCnt;
      assign pollTick = strb.pollRun && (gapCnt == GAP_W'(POLL_GAP - 1));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)              gapCnt <= '0;
        else if (strb.loadWord) gapCnt <= '0;
        else if (strb.pollRun)  gapCnt <= pollTick ? '0 : gapCnt + 1'b1;
      end
      // R7: polls are never back to back when a gap is configured
      a_r7_poll_spacing: assert property (@(posedge clk) disable iff (!rstN)
        pollTick |=> !pollTick);
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              pollCnt <= '0;
    else if (strb.loadWord) pollCnt <= '0;
    else if (pollTick)      pollCnt <= pollCnt + 1'b1;
  end
  assign lastPoll = (pollCnt == CNT_W'(POLL_LIMIT - 1));

  // R8: the poll count of one wait never passes the limit
  a_r8_poll_bound: assert property (@(posedge clk) disable iff (!rstN)
    pollCnt < CNT_W'(POLL_LIMIT));
  // R2: at most one strobe bit set in the control word
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(ctlQ[RD_BIT:CAPA_BIT]));
endmodule

// File: rtl/phy_cbus_ctrl.sv
module phy_cbus_ctrl
  import phy_cbus_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  input  logic       pollTick,
  input  logic       lastPoll,
  input  logic       ackIn,
  output dpStrobes_t strb,
  output logic       reqReady,
  output logic       rspDone,
  output logic       rspErr
);
  seqState_e stateQ, stateD;
  logic isWriteQ, isWriteD;
  logic finish, fail;

  function automatic logic wantHigh(input seqState_e s);
    return (s == ST_ADDR_HI) || (s == ST_DATA_HI) || (s == ST_WR_HI) || (s == ST_RD_HI);
  endfunction

  always_comb begin
    strb         = '0;
    strb.sel     = W_ZERO;
    strb.pollRun = (stateQ != ST_IDLE);
    stateD       = stateQ;
    isWriteD     = isWriteQ;
    finish       = 1'b0;
    fail         = 1'b0;
    if (stateQ == ST_IDLE) begin
      if (reqValid) begin
        strb.latchReq = 1'b1;
        strb.clearRd  = 1'b1;
        strb.loadWord = 1'b1;
        strb.sel      = W_ADDR_CAP;
        isWriteD      = reqWrite;
        stateD        = ST_ADDR_HI;
      end
    end else if (pollTick) begin
      if (ackIn == wantHigh(stateQ)) begin
        strb.loadWord = 1'b1;
        case (stateQ)
          ST_ADDR_HI: begin strb.sel = W_ADDR; stateD = ST_ADDR_LO; end
          ST_ADDR_LO: begin
            if (isWriteQ) begin strb.sel = W_DATA_CAP; stateD = ST_DATA_HI; end
            else          begin strb.sel = W_RD;       stateD = ST_RD_HI;   end
          end
          ST_DATA_HI: begin strb.sel = W_DATA; stateD = ST_DATA_LO; end
          ST_DATA_LO: begin strb.sel = W_WR;   stateD = ST_WR_HI;   end
          ST_WR_HI:   begin strb.sel = W_DATA; stateD = ST_WR_LO;   end
          ST_WR_LO:   begin strb.sel = W_ZERO; stateD = ST_IDLE; finish = 1'b1; end
          ST_RD_HI:   begin strb.sel = W_ZERO; strb.captureRd = 1'b1; stateD = ST_RD_LO; end
          ST_RD_LO:   begin strb.sel = W_ZERO; stateD = ST_IDLE; finish = 1'b1; end
          default:    begin strb.sel = W_ZERO; stateD = ST_IDLE; end
        endcase
      end else if (lastPoll) begin
        strb.loadWord = 1'b1;
        strb.sel      = W_ZERO;
        stateD        = ST_IDLE;
        finish        = 1'b1;
        fail          = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      isWriteQ <= 1'b0;
      rspDone  <= 1'b0;
      rspErr   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      isWriteQ <= isWriteD;
      rspDone  <= finish;
      rspErr   <= fail;
    end
  end

  assign reqReady = (stateQ == ST_IDLE);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone);
  // R10: error only together with done
  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rstN)
    rspErr |-> rspDone);
  // R9: a taken request makes the block busy on the next cycle
  a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && reqValid) |=> !reqReady);
endmodule

// File: rtl/phy_cbus_master.sv
module phy_cbus_master
  import phy_cbus_pkg::*;
#(
  parameter int POLL_GAP   = 2,
  parameter int POLL_LIMIT = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [PAY_W-1:0]  reqAddr,
  input  logic [PAY_W-1:0]  reqWdata,
  output logic              reqReady,
  output logic              rspDone,
  output logic              rspErr,
  output logic [PAY_W-1:0]  rspRdata,
  output logic [CTL_W-1:0]  ctlWord,
  input  logic [STAT_W-1:0] statWord
);
  dpStrobes_t strb;
  logic pollTick, lastPoll, ackIn;

  phy_cbus_ctrl i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .pollTick (pollTick),
    .lastPoll (lastPoll),
    .ackIn    (ackIn),
    .strb     (strb),
    .reqReady (reqReady),
    .rspDone  (rspDone),
    .rspErr   (rspErr)
  );

  phy_cbus_dpath #(
    .POLL_GAP   (POLL_GAP),
    .POLL_LIMIT (POLL_LIMIT)
  ) i_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .reqAddr  (reqAddr),
    .reqWdata (reqWdata),
    .statWord (statWord),
    .ctlWord  (ctlWord),
    .rdData   (rspRdata),
    .pollTick (pollTick),
    .lastPoll (lastPoll),
    .ackIn    (ackIn)
  );

  // R1/R8: whenever the block is idle the control word is zero
  a_r8_idle_word_zero: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (ctlWord == '0));
endmodule

// File: tb/test_phy_cbus_master.sv
`timescale 1ns/1ps
module test_phy_cbus_master;
  localparam int GAP   = 2;
  localparam int LIMIT = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0, reqWdata = '0;
  logic        reqReady, rspDone, rspErr;
  logic [15:0] rspRdata;
  logic [19:0] ctlWord;
  logic [16:0] statWord;

  always #2 clk = ~clk;

  phy_cbus_master #(.POLL_GAP(GAP), .POLL_LIMIT(LIMIT)) i_phy_cbus_master (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .rspDone(rspDone), .rspErr(rspErr), .rspRdata(rspRdata),
    .ctlWord(ctlWord), .statWord(statWord)
  );

  // PHY responder model: mode 0 normal, 1 ack never rises, 2 ack never falls
  int          lat = 1;
  int          mode = 0;
  int          lcnt;
  logic        ack;
  logic [15:0] statData, capAddr, capData;
  logic [15:0] mem [16];
  logic        target;
  assign target   = |ctlWord[19:16];
  assign statWord = {ack, statData};

  always @(posedge clk) begin
    if (!rstN) begin
      ack <= 1'b0; lcnt <= 0; statData <= '0; capAddr <= '0; capData <= '0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      if (ctlWord[16]) capAddr <= ctlWord[15:0];
      if (ctlWord[17]) capData <= ctlWord[15:0];
      if (target != ack && !(mode == 1 && target) && !(mode == 2 && !target)) begin
        if (lcnt + 1 >= lat) begin
          ack  <= target;
          lcnt <= 0;
          if (target && ctlWord[18]) mem[capAddr[3:0]] <= capData;
          if (target && ctlWord[19]) statData <= mem[capAddr[3:0]];
        end else lcnt <= lcnt + 1;
      end else lcnt <= 0;
    end
  end

  // Observation at the falling edge
  logic [19:0] logQ [32];
  int          logN, doneCnt, errCnt, watchCnt;
  logic [19:0] lastCtl = '0, watchWord = '1;
  always @(negedge clk) begin
    if (ctlWord != lastCtl && logN < 32) begin
      logQ[logN] = ctlWord;
      logN++;
    end
    lastCtl = ctlWord;
    if (ctlWord == watchWord) watchCnt++;
    if (rspDone) doneCnt++;
    if (rspErr) errCnt++;
  end

  int nChecks = 0, nFail = 0;
  logic [19:0] expSeq [8];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic chkSeq(input string req, input int n);
    bit ok = (logN == n);
    int bad = -1;
    for (int i = 0; i < n && ok; i++) if (logQ[i] != expSeq[i]) begin ok = 0; bad = i; end
    if (bad >= 0) chk(0, req, "control word sequence entry", {12'b0, logQ[bad]}, {12'b0, expSeq[bad]});
    else chk(ok, req, "control word sequence length", logN, n);
  endtask

  task automatic runTxn(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        input bit poke);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logN = 0; doneCnt = 0; errCnt = 0; watchCnt = 0;
    reqValid = 1'b1; reqWrite = wr; reqAddr = a; reqWdata = d;
    @(negedge clk);
    reqValid = 1'b0;
    if (poke) begin
      reqValid = 1'b1; reqWrite = 1'b1; reqAddr = 16'h0008; reqWdata = 16'h1111;
      repeat (5) @(negedge clk);
      reqValid = 1'b0;
    end
    for (int k = 0; k < 2000 && doneCnt == 0; k++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic testReset;
    chk(ctlWord == 0, "R1", "control word", ctlWord, 0);
    chk(reqReady == 1, "R1", "ready", reqReady, 1);
    chk(rspDone == 0, "R1", "done", rspDone, 0);
    chk(rspErr == 0, "R1", "error", rspErr, 0);
    chk(rspRdata == 0, "R1", "read data", rspRdata, 0);
  endtask

  task automatic testWrite(input logic [15:0] a, input logic [15:0] d, input bit poke);
    runTxn(1'b1, a, d, poke);
    expSeq[0] = {4'h1, a}; expSeq[1] = {4'h0, a}; expSeq[2] = {4'h2, d};
    expSeq[3] = {4'h0, d}; expSeq[4] = 20'h40000; expSeq[5] = {4'h0, d}; expSeq[6] = 20'h0;
    chkSeq("R5 R4 R2", 7);
    chk(doneCnt == 1, "R10", "done cycles", doneCnt, 1);
    chk(errCnt == 0, "R10", "error cycles", errCnt, 0);
  endtask

  task automatic testRead(input logic [15:0] a, input logic [15:0] exp);
    runTxn(1'b0, a, 16'h0, 1'b0);
    expSeq[0] = {4'h1, a}; expSeq[1] = {4'h0, a}; expSeq[2] = 20'h80000; expSeq[3] = 20'h0;
    chkSeq("R6 R4", 4);
    chk(rspRdata == exp, "R6 R3", "read data", rspRdata, exp);
    chk(errCnt == 0 && doneCnt == 1, "R10", "done/error cycles", {errCnt[15:0], doneCnt[15:0]}, 1);
  endtask

  task automatic testPollSpacing(input int l, input int expCnt);
    lat = l;
    watchWord = 20'h1_00A5;
    runTxn(1'b1, 16'h00A5, 16'h1234, 1'b0);
    chk(watchCnt == expCnt, "R7", "address-capture hold cycles", watchCnt, expCnt);
    chk(errCnt == 0, "R7", "no error", errCnt, 0);
    watchWord = '1;
    lat = 1;
  endtask

  task automatic testLastPoll;
    lat = 19; watchWord = 20'h1_0003;
    runTxn(1'b0, 16'h0003, 16'h0, 1'b0);
    chk(watchCnt == GAP * LIMIT, "R7", "ack at last poll hold cycles", watchCnt, GAP * LIMIT);
    chk(errCnt == 0 && rspRdata == 16'hBEEF, "R7", "ack at last poll result", rspRdata, 16'hBEEF);
    lat = 20;
    runTxn(1'b0, 16'h0003, 16'h0, 1'b0);
    expSeq[0] = 20'h1_0003; expSeq[1] = 20'h0;
    chkSeq("R8", 2);
    chk(watchCnt == GAP * LIMIT, "R8", "timeout hold cycles", watchCnt, GAP * LIMIT);
    chk(errCnt == 1 && doneCnt == 1, "R8", "error with done", {errCnt[15:0], doneCnt[15:0]}, 32'h0001_0001);
    chk(rspRdata == 0, "R10", "read data cleared on accept", rspRdata, 0);
    lat = 1; watchWord = '1;
    repeat (30) @(negedge clk);
  endtask

  task automatic testStuckHigh;
    mode = 2; watchWord = 20'h0_0002;
    runTxn(1'b1, 16'h0002, 16'h7777, 1'b0);
    expSeq[0] = 20'h1_0002; expSeq[1] = 20'h0_0002; expSeq[2] = 20'h0;
    chkSeq("R8", 3);
    chk(watchCnt == GAP * LIMIT, "R8", "stuck ack hold cycles", watchCnt, GAP * LIMIT);
    chk(errCnt == 1, "R8", "error reported", errCnt, 1);
    mode = 0; watchWord = '1;
    repeat (10) @(negedge clk);
    testRead(16'h0002, 16'h0000);
  endtask

  task automatic finishRun;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: run did not complete");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testWrite(16'h0003, 16'hBEEF, 1'b0);
    testRead(16'h0003, 16'hBEEF);
    testWrite(16'hFFFF, 16'hFFFF, 1'b0);
    testRead(16'hFFFF, 16'hFFFF);
    testPollSpacing(3, 4);
    testPollSpacing(4, 6);
    testRead(16'h00A5, 16'h1234);
    testWrite(16'h0007, 16'h5A5A, 1'b1);   // R9 poke while busy
    testRead(16'h0008, 16'h0000);           // R9 poked write never happened
    chk(reqReady == 1 && ctlWord == 0, "R9", "idle after poke", ctlWord, 0);
    testLastPoll();
    testStuckHigh();
    testRead(16'h0007, 16'h5A5A);
    finishRun();
  end
endmodule